// File: doc/BRIEF.md
# Byte Increment/Decrement Execute Unit

This block executes the single-byte increment and decrement instructions of a small 8-bit accumulator-style core. It works on the three general registers (accumulator, first and second general register) or on one byte of a directly addressed working page in data memory. The sequencer outside the block fetches the opcode and its operand byte. It holds `start` for one cycle while the unit is idle, then waits for `done`.

An increment that wraps to 0x00, or a decrement that wraps to 0xFF, raises the skip-next-instruction bit in the status word. The carry bit passes through untouched. The zero bit follows the 8-bit result. The memory form forms a 16-bit address: the high byte comes from the page register value on `page_hi`, and the low byte is the instruction's operand. It then runs a timed read, modify and write sequence. Opcodes outside the group raise a one-cycle error and change nothing.

Top module: `incdec_unit`

## Requirements
- R1: After reset the unit is idle, and `busy`, `done`, `illegal_err`, `rf_we`, `mem_re`, `mem_we` and `psw_we` are all 0.
- R2: Opcodes 0x41, 0x42 and 0x43 add one, modulo 256, to the register selected on `rf_sel` (0 = accumulator, 1 = first, 2 = second). The result is written through `rf_we`/`rf_wdata`.
- R3: Opcodes 0x51, 0x52 and 0x53 subtract one, modulo 256, from the register selected as 0, 1 and 2 respectively.
- R4: Opcode 0x20 (increment) and opcode 0x30 (decrement) act on the memory byte at address {`page_hi`, `operand`}. The unit reads the byte with `mem_re`, and the read data returns on the next cycle. It then writes the read value plus or minus one, modulo 256. The read always comes before the write, and the register port is not written.
- R5: The status word has carry at bit 0, zero at bit 1 and skip at bit 2. The skip bit is set when an increment produces 0x00 or a decrement produces 0xFF. Otherwise the skip bit equals the skip bit captured at start, so the unit never clears it.
- R6: The zero bit of the written status word is 1 exactly when the 8-bit result is 0x00.
- R7: The carry bit of the written status word equals the carry bit of `psw_in` captured at start, for every opcode in the group.
- R8: `done` and `psw_we` pulse together for exactly one cycle. In the default timing, `done` is high in the 4th cycle after acceptance for register forms and in the 13th cycle for memory forms (6 and 17 with `SLOW_TIMING`). For a memory form, `done` comes only in the cycle where `mem_we` and `mem_wready` are both high. Each cycle of write stall adds one cycle.
- R9: Any other opcode, including 0x40 and 0x50, raises `illegal_err` for one cycle in the cycle after start. `busy` stays low, and no register, memory or status write takes place.
- R10: `start` and `opcode` are ignored while the unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Execute request, sampled while idle |
| opcode | input | 8 | Instruction byte |
| operand | input | 8 | Second instruction byte (working-page offset) |
| page_hi | input | 8 | Page register value, high address byte |
| psw_in | input | 3 | Status word before the instruction |
| rf_sel | output | 2 | Register select: 0 accumulator, 1 first, 2 second |
| rf_rdata | input | 8 | Register read data for `rf_sel` |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | 8 | Register write data |
| mem_addr | output | 16 | Memory byte address |
| mem_re | output | 1 | Memory read strobe, data returns next cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_we | output | 1 | Memory write request, held until accepted |
| mem_wdata | output | 8 | Memory write data |
| mem_wready | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction complete |
| psw_we | output | 1 | Status word write strobe |
| psw_out | output | 3 | Updated status word |
| illegal_err | output | 1 | Opcode not in the group |

## Verification
Operand values are drawn mostly from 0x00, 0x01, 0xFE and 0xFF, with some fully random values. This separates the two wrap points from their neighbours, so a skip raised on the wrong edge or at the wrong direction shows up, and so does a zero flag that ignores the result. The incoming carry and skip bits are randomised against each result, which shows whether carry is passed through and whether an existing skip is ever dropped. Memory writes are stalled for zero to three cycles, which tests that completion waits for write acceptance. Illegal and random opcodes, and a start request issued mid-instruction, test that nothing outside the group writes state.

// File: rtl/incdec_pkg.sv
package incdec_pkg;

    localparam int PSW_W  = 3;
    localparam int CY_BIT = 0;
    localparam int Z_BIT  = 1;
    localparam int SK_BIT = 2;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_REG  = 2'd1,
        K_MEM  = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_ERR  = 2'd2
    } st_e;

    typedef struct packed {
        kind_e      kind;
        logic       dec;
        logic [1:0] rsel;
    } op_t;

endpackage

// File: rtl/incdec_decode.sv
module incdec_decode
    import incdec_pkg::*;
(
    input  logic [7:0] opcode,
    output op_t        op
);
    always_comb begin
        op = '{kind: K_NONE, dec: 1'b0, rsel: 2'd0};
        unique case (opcode)
            8'h41: op = '{kind: K_REG, dec: 1'b0, rsel: 2'd0};
            8'h42: op = '{kind: K_REG, dec: 1'b0, rsel: 2'd1};
            8'h43: op = '{kind: K_REG, dec: 1'b0, rsel: 2'd2};
            8'h51: op = '{kind: K_REG, dec: 1'b1, rsel: 2'd0};
            8'h52: op = '{kind: K_REG, dec: 1'b1, rsel: 2'd1};
            8'h53: op = '{kind: K_REG, dec: 1'b1, rsel: 2'd2};
            8'h20: op = '{kind: K_MEM, dec: 1'b0, rsel: 2'd0};
            8'h30: op = '{kind: K_MEM, dec: 1'b1, rsel: 2'd0};
            default: op = '{kind: K_NONE, dec: 1'b0, rsel: 2'd0};
        endcase
    end
endmodule

// File: rtl/incdec_alu.sv
module incdec_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          dec,
    output logic [DW-1:0] res,
    output logic          wrap,
    output logic          zero
);
    localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] ONES = {DW{1'b1}};

    always_comb begin
        res  = dec ? (data - ONE) : (data + ONE);
        zero = (res == '0);
        wrap = dec ? (res == ONES) : zero;
    end
endmodule

// File: rtl/incdec_timing.sv
module incdec_timing
    import incdec_pkg::*;
#(
    parameter bit SLOW_TIMING = 1'b0,
    parameter int REG_FAST    = 4,
    parameter int MEM_FAST    = 13,
    parameter int REG_SLOW    = 6,
    parameter int MEM_SLOW    = 17,
    parameter int CW          = 5
) (
    input  kind_e         kind,
    output logic [CW-1:0] cap_cnt,
    output logic [CW-1:0] mod_cnt,
    output logic [CW-1:0] last_cnt
);
    logic [CW-1:0] reg_last, mem_last;

    generate
        if (SLOW_TIMING) begin : g_slow
            assign reg_last = CW'(REG_SLOW);
            assign mem_last = CW'(MEM_SLOW);
        end else begin : g_fast
            assign reg_last = CW'(REG_FAST);
            assign mem_last = CW'(MEM_FAST);
        end
    endgenerate

    always_comb begin
        if (kind == K_MEM) begin
            cap_cnt  = CW'(3);
            mod_cnt  = CW'(4);
            last_cnt = mem_last;
        end else begin
            cap_cnt  = CW'(1);
            mod_cnt  = CW'(2);
            last_cnt = reg_last;
        end
    end
endmodule

// File: rtl/incdec_unit.sv
module incdec_unit
    import incdec_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 16,
    parameter bit SLOW_TIMING = 1'b0,
    parameter int REG_FAST    = 4,
    parameter int MEM_FAST    = 13,
    parameter int REG_SLOW    = 6,
    parameter int MEM_SLOW    = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DW-1:0]     operand,
    input  logic [AW-DW-1:0]  page_hi,
    input  logic [PSW_W-1:0]  psw_in,
    output logic [1:0]        rf_sel,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [DW-1:0]     rf_wdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_re,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_wready,
    output logic              busy,
    output logic              done,
    output logic              psw_we,
    output logic [PSW_W-1:0]  psw_out,
    output logic              illegal_err
);
    localparam int PW     = AW - DW;
    localparam int MAXCNT = (MEM_SLOW > MEM_FAST) ? MEM_SLOW : MEM_FAST;
    localparam int CW     = $clog2(MAXCNT + 1);

    typedef struct packed {
        st_e              st;
        logic [CW-1:0]    cnt;
        op_t              op;
        logic [DW-1:0]    imm;
        logic [PW-1:0]    page;
        logic [DW-1:0]    data;
        logic [DW-1:0]    res;
        logic             wrap;
        logic             zero;
        logic [PSW_W-1:0] psw;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    op_t           dec_op;
    logic [DW-1:0] alu_res;
    logic          alu_wrap, alu_zero;
    logic [CW-1:0] cap_cnt, mod_cnt, last_cnt;
    logic          run, last_hit, is_reg, is_mem;

    incdec_decode u_decode (
        .opcode (opcode),
        .op     (dec_op)
    );

    incdec_alu #(.DW(DW)) u_alu (
        .data (ctx_q.data),
        .dec  (ctx_q.op.dec),
        .res  (alu_res),
        .wrap (alu_wrap),
        .zero (alu_zero)
    );

    incdec_timing #(
        .SLOW_TIMING (SLOW_TIMING),
        .REG_FAST    (REG_FAST),
        .MEM_FAST    (MEM_FAST),
        .REG_SLOW    (REG_SLOW),
        .MEM_SLOW    (MEM_SLOW),
        .CW          (CW)
    ) u_timing (
        .kind     (ctx_q.op.kind),
        .cap_cnt  (cap_cnt),
        .mod_cnt  (mod_cnt),
        .last_cnt (last_cnt)
    );

    assign run      = (ctx_q.st == S_RUN);
    assign is_reg   = run && (ctx_q.op.kind == K_REG);
    assign is_mem   = run && (ctx_q.op.kind == K_MEM);
    assign last_hit = run && (ctx_q.cnt == last_cnt);

    // next-state logic
    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            S_IDLE: begin
                if (start) begin
                    if (dec_op.kind == K_NONE) begin
                        ctx_d.st = S_ERR;
                    end else begin
                        ctx_d.st   = S_RUN;
                        ctx_d.cnt  = CW'(1);
                        ctx_d.op   = dec_op;
                        ctx_d.imm  = operand;
                        ctx_d.page = page_hi;
                        ctx_d.psw  = psw_in;
                        ctx_d.wrap = 1'b0;
                        ctx_d.zero = 1'b0;
                    end
                end
            end
            S_ERR: begin
                ctx_d.st = S_IDLE;
            end
            S_RUN: begin
                if (ctx_q.cnt == cap_cnt) begin
                    ctx_d.data = (ctx_q.op.kind == K_MEM) ? mem_rdata : rf_rdata;
                end
                if (ctx_q.cnt == mod_cnt) begin
                    ctx_d.res  = alu_res;
                    ctx_d.wrap = alu_wrap;
                    ctx_d.zero = alu_zero;
                end
                if (ctx_q.cnt == last_cnt) begin
                    if (ctx_q.op.kind == K_REG || mem_wready) begin
                        ctx_d.st  = S_IDLE;
                        ctx_d.cnt = '0;
                    end
                end else begin
                    ctx_d.cnt = ctx_q.cnt + CW'(1);
                end
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    // outputs
    always_comb begin
        logic [PSW_W-1:0] w;
        busy        = run;
        illegal_err = (ctx_q.st == S_ERR);
        rf_sel      = is_reg ? ctx_q.op.rsel : 2'd0;
        rf_we       = last_hit && (ctx_q.op.kind == K_REG);
        rf_wdata    = rf_we ? ctx_q.res : '0;
        mem_addr    = is_mem ? {ctx_q.page, ctx_q.imm} : '0;
        mem_re      = is_mem && (ctx_q.cnt == CW'(2));
        mem_we      = last_hit && (ctx_q.op.kind == K_MEM);
        mem_wdata   = mem_we ? ctx_q.res : '0;
        done        = rf_we || (mem_we && mem_wready);
        psw_we      = done;
        w           = ctx_q.psw;
        w[Z_BIT]    = ctx_q.zero;
        w[SK_BIT]   = ctx_q.psw[SK_BIT] | ctx_q.wrap;
        psw_out     = done ? w : '0;
    end
endmodule

// File: rtl/incdec_chk.sv
module incdec_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          op_dec,
    input logic          cy_in,
    input logic          sk_in,
    input logic          busy,
    input logic          done,
    input logic          rf_we,
    input logic [DW-1:0] rf_wdata,
    input logic          mem_re,
    input logic [DW-1:0] mem_rdata,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_wready,
    input logic          psw_we,
    input logic [2:0]    psw_out,
    input logic          illegal_err
);
    logic          cap_dec, cap_cy, cap_sk, re_d;
    logic [DW-1:0] rd_cap, wr_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_dec <= 1'b0;
            cap_cy  <= 1'b0;
            cap_sk  <= 1'b0;
            re_d    <= 1'b0;
            rd_cap  <= '0;
        end else begin
            if (start && !busy && !illegal_err) begin
                cap_dec <= op_dec;
                cap_cy  <= cy_in;
                cap_sk  <= sk_in;
            end
            re_d <= mem_re;
            if (re_d) rd_cap <= mem_rdata;
        end
    end

    assign wr_val = rf_we ? rf_wdata : mem_wdata;

    // R4
    mem_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata == (cap_dec ? rd_cap - DW'(1) : rd_cap + DW'(1)));
    // R4
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && mem_we));
    // R5
    skip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_we && cap_sk) |-> psw_out[2]);
    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_we |-> (psw_out[1] == (wr_val == '0)));
    // R7
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psw_we |-> (psw_out[0] == cap_cy));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_wack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wready) |-> done);
    // R8
    done_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done == psw_we);
    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |-> (!busy && !rf_we && !mem_we && !psw_we));
endmodule

bind incdec_unit incdec_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_dec      (opcode[4]),
    .cy_in       (psw_in[0]),
    .sk_in       (psw_in[2]),
    .busy        (busy),
    .done        (done),
    .rf_we       (rf_we),
    .rf_wdata    (rf_wdata),
    .mem_re      (mem_re),
    .mem_rdata   (mem_rdata),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .mem_wready  (mem_wready),
    .psw_we      (psw_we),
    .psw_out     (psw_out),
    .illegal_err (illegal_err)
);

// File: tb/tb_incdec_unit.sv
module tb_incdec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, operand = 8'h00, page_hi = 8'h00;
    logic [2:0]  psw_in = 3'b000;
    logic [1:0]  rf_sel;
    logic [7:0]  rf_rdata, rf_wdata, mem_rdata, mem_wdata;
    logic        rf_we, mem_re, mem_we, mem_wready, busy, done, psw_we, illegal_err;
    logic [15:0] mem_addr;
    logic [2:0]  psw_out;

    logic [7:0]  rf_m [4];
    logic [7:0]  mem_m [256];
    int          stall_n = 0;
    int          wcnt = 0;
    int          errors = 0, checks = 0;

    always #5 clk = ~clk;

    incdec_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .page_hi(page_hi), .psw_in(psw_in), .rf_sel(rf_sel), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_wready(mem_wready), .busy(busy), .done(done), .psw_we(psw_we),
        .psw_out(psw_out), .illegal_err(illegal_err)
    );

    assign rf_rdata   = rf_m[rf_sel];
    assign mem_wready = mem_we && (wcnt >= stall_n);

    initial begin
        for (int i = 0; i < 4; i++) rf_m[i] = 8'h00;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        mem_rdata = 8'h00;
    end

    always @(posedge clk) begin
        wcnt <= mem_we ? wcnt + 1 : 0;
        if (mem_re) mem_rdata <= mem_m[mem_addr[7:0]];
        if (mem_we && mem_wready) mem_m[mem_addr[7:0]] <= mem_wdata;
        if (rf_we) rf_m[rf_sel] <= rf_wdata;
    end

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 = not in group, 1 = register form, 2 = memory form
    function automatic int kind_of(input logic [7:0] op);
        case (op)
            8'h41, 8'h42, 8'h43, 8'h51, 8'h52, 8'h53: return 1;
            8'h20, 8'h30: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_res(input logic [7:0] op, input logic [7:0] v);
        return op[4] ? v - 8'd1 : v + 8'd1;
    endfunction

    function automatic logic [2:0] exp_psw(input logic [7:0] op, input logic [7:0] v,
                                          input logic [2:0] pin);
        logic [7:0] r;
        logic       wr;
        r  = exp_res(op, v);
        wr = op[4] ? (r == 8'hFF) : (r == 8'h00);
        return {pin[2] | wr, (r == 8'h00), pin[0]};
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [7:0] imm, input logic [7:0] pg,
                          input logic [2:0] pin, input int stall, input bit poke);
        int         kd, k, re_k, exp_lat;
        logic [7:0] v, snap0, snap1, snap2, snapm, exp_v;
        logic [15:0] re_addr;
        bit         we_seen;
        string      rq;
        kd      = kind_of(op);
        stall_n = stall;
        snap0 = rf_m[0]; snap1 = rf_m[1]; snap2 = rf_m[2]; snapm = mem_m[imm];
        v  = (kd == 2) ? mem_m[imm] : rf_m[op[1:0] - 2'd1];
        rq = (kd == 2) ? "R4" : (op[4] ? "R3" : "R2");
        @(negedge clk);
        opcode = op; operand = imm; page_hi = pg; psw_in = pin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (kd == 0) begin
            // R9 error pulse, no activity
            chk(illegal_err == 1'b1 && busy == 1'b0, "R9", {illegal_err, busy}, 2'b10);
            we_seen = rf_we | mem_we | psw_we;
            @(negedge clk);
            we_seen |= rf_we | mem_we | psw_we;
            chk(illegal_err == 1'b0, "R9", illegal_err, 0);
            chk(!we_seen, "R9", we_seen, 0);
            chk(rf_m[0] == snap0 && rf_m[1] == snap1 && rf_m[2] == snap2 && mem_m[imm] == snapm,
                "R9", {rf_m[0], rf_m[1], rf_m[2]}, {snap0, snap1, snap2});
            return;
        end
        k = 1; re_k = 0; re_addr = 16'h0;
        while (!done && k < 80) begin
            if (mem_re) begin re_k = k; re_addr = mem_addr; end
            if (poke && k == 2) begin start = 1'b1; opcode = 8'h51; end
            else start = 1'b0;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        exp_lat = (kd == 2) ? 13 + stall : 4;
        chk(k == exp_lat, "R8", k, exp_lat);
        chk(psw_we == 1'b1, "R8", psw_we, 1);
        chk(psw_out == exp_psw(op, v, pin), "R5 R6 R7", psw_out, exp_psw(op, v, pin));
        exp_v = exp_res(op, v);
        if (kd == 2) begin
            chk(re_k != 0 && re_k < k, "R4", re_k, 2);
            chk(re_addr == {pg, imm}, "R4", re_addr, {pg, imm});
            chk(mem_we && mem_wdata == exp_v && !rf_we, "R4", mem_wdata, exp_v);
        end else begin
            chk(rf_we && rf_sel == op[1:0] - 2'd1 && rf_wdata == exp_v, rq, rf_wdata, exp_v);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 R10", {done, busy}, 0);
        if (kd == 2) chk(mem_m[imm] == exp_v, "R4", mem_m[imm], exp_v);
        else         chk(rf_m[op[1:0] - 2'd1] == exp_v, rq, rf_m[op[1:0] - 2'd1], exp_v);
        if (poke) begin
            // R10 the mid-run request must not have started a second operation
            chk(rf_m[0] == ((op == 8'h41 || op == 8'h51) ? exp_v : snap0), "R10", rf_m[0], snap0);
        end
    endtask

    function automatic logic [7:0] pick_val();
        int r;
        r = $urandom_range(0, 5);
        case (r)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'hFE;
            3: return 8'hFF;
            default: return 8'($urandom());
        endcase
    endfunction

    logic [7:0] ops [10] = '{8'h41, 8'h42, 8'h43, 8'h51, 8'h52, 8'h53, 8'h20, 8'h30, 8'h40, 8'h50};

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, done, illegal_err, rf_we, mem_re, mem_we, psw_we} == 7'd0, "R1",
            {busy, done, illegal_err, rf_we, mem_re, mem_we, psw_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, illegal_err, psw_we} == 4'd0, "R1", {busy, done, illegal_err, psw_we}, 0);

        // directed corners
        rf_m[0] = 8'hFF; run_op(8'h41, 8'h00, 8'h00, 3'b001, 0, 0); // R2 wrap, carry kept
        rf_m[1] = 8'h00; run_op(8'h52, 8'h00, 8'h00, 3'b000, 0, 0); // R3 wrap to FF
        rf_m[2] = 8'h01; run_op(8'h53, 8'h00, 8'h00, 3'b100, 0, 0); // R6 zero, R5 skip kept
        rf_m[2] = 8'h7F; run_op(8'h43, 8'h00, 8'h00, 3'b101, 0, 0); // R5 no wrap, keep skip
        mem_m[8'h3C] = 8'hFF; run_op(8'h20, 8'h3C, 8'hA5, 3'b000, 0, 0); // R4 inc wrap
        mem_m[8'h3D] = 8'h00; run_op(8'h30, 8'h3D, 8'h12, 3'b001, 2, 0); // R4 dec wrap, stall
        run_op(8'h40, 8'h10, 8'h00, 3'b000, 0, 0); // R9
        run_op(8'h50, 8'h10, 8'h00, 3'b111, 0, 0); // R9
        rf_m[1] = 8'h10; run_op(8'h42, 8'h00, 8'h00, 3'b000, 0, 1); // R10

        // constrained random
        for (int n = 0; n < 120; n++) begin
            logic [7:0] op, imm;
            op  = ($urandom_range(0, 9) == 0) ? 8'($urandom()) : ops[$urandom_range(0, 9)];
            imm = 8'($urandom());
            if (kind_of(op) == 2) mem_m[imm] = pick_val();
            else if (kind_of(op) == 1) rf_m[op[1:0] - 2'd1] = pick_val();
            run_op(op, imm, 8'($urandom()), 3'($urandom()), $urandom_range(0, 3),
                   $urandom_range(0, 7) == 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule